// File: doc/BRIEF.md
# Strobe-Started Serial ADC Host Controller

This block is the host-side master for a 12-bit converter that is started by a low-going strobe and read out over a serial clock that the host generates. A single request runs one of four jobs: one conversion, a burst of back-to-back conversions, entry into partial power-down, or entry into full power-down. Power-down is entered only through the position of the strobe's rising edge within a 16-clock frame. Full power-down uses two such frames in a row.

Every job is built from identical frames. In each frame the strobe falls while the serial clock is low. Half a serial period later, 16 serial clock pulses follow. The strobe rises at a point that depends on the job, and a gap of one serial period with the strobe high closes the frame. The serial clock runs at the system clock divided by an even parameter `DIV`. If a conversion is requested while the converter is powered down, the block first runs a wake-up frame, with the strobe low for all 16 pulses, and discards its result. Each result is returned with a one-cycle valid pulse. The result is zero-extended or sign-extended to 16 bits, as set by `SIGNED_OUT`.

Top module: `strobe_adc_host`

## Requirements
- R1: While and after reset, `cnv_n_o` is high, `sclk_o` is low, `busy_o` and `valid_o` are low, and `pd_o` is 0 (normal).
- R2: `sclk_o` is low whenever `busy_o` is low. Within a frame, each high phase and each low phase lasts DIV/2 system cycles, and exactly 16 rising edges occur per frame.
- R3: The request (`req_i` high while idle) is sampled at a clock edge. For a single conversion (`op_i`=0), `cnv_n_o` is low from the cycle after that edge. The first rising edge of `sclk_o` comes DIV/2 cycles later. `cnv_n_o` stays low through the 16th falling edge and rises DIV/2 cycles after it. A frame lasts 35·DIV/2 cycles.
- R4: `sdi_i` is sampled each time `sclk_o` rises. The frame carries 3 leading zero bits, then result bit 11 down to bit 0, MSB first: bit 11 is read at the 4th rising edge, bit 0 at the 15th, and the 16th sample is ignored.
- R5: `valid_o` pulses for exactly one cycle, 33·DIV/2 cycles after a conversion frame starts. `data_o` holds the result: zero-extended when SIGNED_OUT=0, and sign-extended from result bit 11 when SIGNED_OUT=1.
- R6: A burst (`op_i`=1) runs `count_i` conversion frames back to back, and a count of 0 runs one. In every frame except the last, `cnv_n_o` rises at the 15th falling edge of `sclk_o`. The last frame ends like a single conversion.
- R7: Partial power-down (`op_i`=2) runs one frame in which `cnv_n_o` rises at the falling edge after rising edge PD_EDGE. That frame gives no valid pulse, and afterwards `pd_o`=1.
- R8: Full power-down (`op_i`=3) runs two such frames, with no valid pulse, and afterwards `pd_o`=2.
- R9: A conversion or burst request while `pd_o`≠0 is preceded by one wake-up frame. In that frame `cnv_n_o` stays low through all 16 clock pulses, as in R3, and no valid pulse is given. `pd_o` is 0 after it.
- R10: `busy_o` is high from the cycle after acceptance until the last frame ends. Requests while busy are ignored. Power-down requests while `pd_o`≠0 are ignored: no strobe, no clock, `busy_o` stays low and `pd_o` is unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Request strobe, taken when idle |
| op_i | input | 2 | Job: 0 single, 1 burst, 2 partial power-down, 3 full power-down |
| count_i | input | CNT_W | Burst length (0 treated as 1) |
| busy_o | output | 1 | A job is in progress |
| cnv_n_o | output | 1 | Conversion strobe to the converter, active low |
| sclk_o | output | 1 | Serial clock to the converter |
| sdi_i | input | 1 | Serial data from the converter |
| valid_o | output | 1 | One-cycle result strobe |
| data_o | output | 16 | Extended 12-bit result |
| pd_o | output | 2 | Power state: 0 normal, 1 partial, 2 full |

## Verification
The assertions check, on every cycle, the idle levels of the strobe and the serial clock. They also check that the strobe only falls while the clock is low, that the high phase of the clock has the correct width, that each valid pulse lasts one cycle and never occurs while powered down, and that the power state holds steady while idle. Other behaviour can only be shown by the bench's scenarios, which compare each cycle against a reference timeline. These are: where the strobe rises in each kind of frame, the insertion of the wake-up frame and the discarding of its data, bit alignment and sign extension, burst length, and the ignoring of requests.

// File: rtl/strobe_adc_host.sv
module strobe_adc_host #(
  parameter int DIV        = 4,
  parameter bit SIGNED_OUT = 1'b0,
  parameter int PD_EDGE    = 8,
  parameter int CNT_W      = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_i,
  input  logic [1:0]       op_i,
  input  logic [CNT_W-1:0] count_i,
  output logic             busy_o,
  output logic             cnv_n_o,
  output logic             sclk_o,
  input  logic             sdi_i,
  output logic             valid_o,
  output logic [15:0]      data_o,
  output logic [1:0]       pd_o
);
  localparam int HALF = DIV / 2;
  localparam int HW   = $clog2(HALF) + 1;
  localparam logic [5:0] H_LAST  = 6'd34;
  localparam logic [5:0] H_DONE  = 6'd33;
  localparam logic [5:0] H_CONT  = 6'd30;
  localparam logic [5:0] H_PD    = 6'(2 * PD_EDGE);
  localparam logic [1:0] OP_ONE = 2'd0, OP_RUN = 2'd1, OP_PPD = 2'd2, OP_FPD = 2'd3;

  logic             active;
  logic [5:0]       h;
  logic [HW-1:0]    cnt;
  logic [CNT_W-1:0] left;
  logic [1:0]       op_q;
  logic             wake;
  logic [15:0]      sh;
  logic [5:0]       rise_h;

  wire        tick   = cnt == HW'(HALF - 1);
  wire [5:0]  hn     = h + 6'd1;
  wire        accept = !active && req_i && !(op_i[1] && pd_o != 2'd0);
  wire        conv   = !wake && !op_q[1];
  wire        pulse  = hn[0] && hn <= 6'd31;
  wire [11:0] res    = sh[12:1];

  assign busy_o = active;

  always_comb begin
    if (wake || op_q == OP_ONE)  rise_h = H_DONE;
    else if (op_q == OP_RUN)     rise_h = (left == CNT_W'(1)) ? H_DONE : H_CONT;
    else                         rise_h = H_PD;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active  <= 1'b0;
      h       <= '0;
      cnt     <= '0;
      left    <= '0;
      op_q    <= OP_ONE;
      wake    <= 1'b0;
      sh      <= '0;
      cnv_n_o <= 1'b1;
      sclk_o  <= 1'b0;
      valid_o <= 1'b0;
      data_o  <= '0;
      pd_o    <= 2'd0;
    end else begin
      valid_o <= 1'b0;
      if (accept) begin
        active  <= 1'b1;
        h       <= '0;
        cnt     <= '0;
        op_q    <= op_i;
        cnv_n_o <= 1'b0;
        wake    <= !op_i[1] && pd_o != 2'd0;
        if (op_i == OP_FPD)                       left <= CNT_W'(2);
        else if (op_i == OP_RUN && count_i != '0) left <= count_i;
        else                                      left <= CNT_W'(1);
      end else if (active) begin
        if (!tick) begin
          cnt <= cnt + HW'(1);
        end else begin
          cnt <= '0;
          if (h == H_LAST) begin
            h <= '0;
            if (wake) begin
              wake    <= 1'b0;
              pd_o    <= 2'd0;
              cnv_n_o <= 1'b0;
            end else if (left == CNT_W'(1)) begin
              active <= 1'b0;
              if (op_q == OP_PPD) pd_o <= 2'd1;
              if (op_q == OP_FPD) pd_o <= 2'd2;
            end else begin
              left    <= left - CNT_W'(1);
              cnv_n_o <= 1'b0;
            end
          end else begin
            h      <= hn;
            sclk_o <= pulse;
            if (hn >= rise_h) cnv_n_o <= 1'b1;
            if (pulse) sh <= {sh[14:0], sdi_i};
            if (hn == H_DONE && conv) begin
              valid_o <= 1'b1;
              data_o  <= SIGNED_OUT ? {{4{res[11]}}, res} : {4'b0000, res};
            end
          end
        end
      end
    end
  end
endmodule

module strobe_adc_host_chk #(
  parameter int DIV = 4
) (
  input logic       clk,
  input logic       rst_n,
  input logic       busy_o,
  input logic       cnv_n_o,
  input logic       sclk_o,
  input logic       valid_o,
  input logic [1:0] pd_o
);
  localparam int HALF = DIV / 2;
  int hi_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_cnt <= 0;
    end else if (sclk_o) begin
      hi_cnt <= hi_cnt + 1;
    end else begin
      if (hi_cnt != 0) begin
        a_r2_high_width: assert (hi_cnt == HALF);
      end
      hi_cnt <= 0;
    end
  end

  a_r2_sclk_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> !sclk_o);
  a_r3_strobe_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> cnv_n_o);
  a_r3_strobe_falls_clock_low: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cnv_n_o) |-> !sclk_o);
  a_r5_valid_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |=> !valid_o);
  a_r9_no_result_powered_down: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> pd_o == 2'd0);
  a_r10_pd_steady_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && !$past(busy_o)) |-> $stable(pd_o));
endmodule

bind strobe_adc_host strobe_adc_host_chk #(.DIV(DIV)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy_o(busy_o), .cnv_n_o(cnv_n_o),
  .sclk_o(sclk_o), .valid_o(valid_o), .pd_o(pd_o)
);

// File: tb/strobe_adc_host_test.sv
module strobe_adc_host_test;
  localparam int DIV = 6;
  localparam int H = DIV / 2;
  localparam int PD_EDGE = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req = 1'b0;
  logic [1:0] op = 2'd0;
  logic [7:0] count = 8'd0;
  logic sdi = 1'b0;
  logic busy, cnv_n, sclk, valid, busy_s, cnv_n_s, sclk_s, valid_s;
  logic [15:0] data, data_s;
  logic [1:0] pd, pd_s;

  always #4 clk = ~clk;

  strobe_adc_host #(.DIV(DIV), .SIGNED_OUT(1'b0), .PD_EDGE(PD_EDGE)) uut (
    .clk(clk), .rst_n(rst_n), .req_i(req), .op_i(op), .count_i(count),
    .busy_o(busy), .cnv_n_o(cnv_n), .sclk_o(sclk), .sdi_i(sdi),
    .valid_o(valid), .data_o(data), .pd_o(pd));

  strobe_adc_host #(.DIV(DIV), .SIGNED_OUT(1'b1), .PD_EDGE(PD_EDGE)) uut_s (
    .clk(clk), .rst_n(rst_n), .req_i(req), .op_i(op), .count_i(count),
    .busy_o(busy_s), .cnv_n_o(cnv_n_s), .sclk_o(sclk_s), .sdi_i(sdi),
    .valid_o(valid_s), .data_o(data_s), .pd_o(pd_s));

  int total = 0;
  int bad = 0;
  int pn = 0;
  int fc = 0;
  int fbit = 0;
  logic [1:0] exp_pd = 2'd0;
  logic [15:0] fr = '0;
  logic [7:0] q[$];
  logic [15:0] dq[$];
  logic [15:0] dqs[$];

  function automatic logic [11:0] dval(int n);
    return 12'((n * 1237 + 2150) % 4096);
  endfunction

  function automatic string tname(int t);
    case (t)
      1: return "R3";
      2: return "R6";
      3: return "R7";
      4: return "R8";
      5: return "R9";
      default: return "R1";
    endcase
  endfunction

  task automatic chk(input bit ok, input string r, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", r, act, exp, $time);
    end
  endtask

  // converter model: strobe fall loads a frame, each falling sclk presents the next bit
  always @(negedge cnv_n) begin
    fr = {3'b000, dval(fc), 1'b0};
    fc++;
    fbit = 0;
    sdi <= 1'b0;
  end
  always @(negedge sclk) begin
    fbit++;
    if (fbit <= 15) sdi <= fr[15 - fbit];
  end

  task automatic plan_frame(input int tag, input int rise, input bit conv);
    logic [11:0] d;
    d = dval(pn);
    pn++;
    for (int j = 0; j < 35 * H; j++) begin
      int hh;
      hh = j / H;
      q.push_back({1'b0, 3'(tag), (conv && j == 33 * H), (hh % 2 == 1 && hh <= 31),
                   (hh >= rise), 1'b1});
    end
    if (conv) begin
      dq.push_back({4'b0000, d});
      dqs.push_back({{4{d[11]}}, d});
    end
  endtask

  // reference timeline compared every cycle
  always @(posedge clk) begin
    logic [7:0] e;
    #2;
    e = (q.size() != 0) ? q.pop_front() : 8'b0000_0010;
    chk(busy == e[0], "R10 busy", 16'(busy), 16'(e[0]));
    chk(cnv_n == e[1], tname(int'(e[6:4])), 16'(cnv_n), 16'(e[1]));
    chk(sclk == e[2], "R2 sclk", 16'(sclk), 16'(e[2]));
    chk(valid == e[3] && valid_s == e[3], "R5 valid", 16'(valid), 16'(e[3]));
    if (e[3]) begin
      logic [15:0] du, ds;
      du = dq.pop_front();
      ds = dqs.pop_front();
      chk(data == du, "R4 data", data, du);
      chk(data_s == ds, "R5 signed data", data_s, ds);
    end
  end

  task automatic run_op(input logic [1:0] o, input logic [7:0] c, input bit poke);
    @(negedge clk);
    req = 1'b1;
    op = o;
    count = c;
    if (!(o[1] && exp_pd != 2'd0)) begin
      if (!o[1] && exp_pd != 2'd0) begin
        plan_frame(5, 33, 1'b0);
        exp_pd = 2'd0;
      end
      case (o)
        2'd0: plan_frame(1, 33, 1'b1);
        2'd1: begin
          int n;
          n = (c == 0) ? 1 : int'(c);
          for (int i = 0; i < n; i++) plan_frame(2, (i == n - 1) ? 33 : 30, 1'b1);
        end
        2'd2: begin plan_frame(3, 2 * PD_EDGE, 1'b0); exp_pd = 2'd1; end
        default: begin
          plan_frame(4, 2 * PD_EDGE, 1'b0);
          plan_frame(4, 2 * PD_EDGE, 1'b0);
          exp_pd = 2'd2;
        end
      endcase
    end
    @(negedge clk);
    req = 1'b0;
    if (poke) begin
      repeat (20) @(negedge clk);
      req = 1'b1;   // R10: request while busy must be ignored
      op = 2'd2;
      @(negedge clk);
      req = 1'b0;
    end
    while (q.size() != 0) @(negedge clk);
    repeat (4) @(negedge clk);
    chk(pd == exp_pd && pd_s == exp_pd, "R7/R8/R9 pd state", 16'(pd), 16'(exp_pd));
  endtask

  initial begin
    #(8 * 150000);
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(cnv_n && !sclk && !busy && !valid && pd == 2'd0, "R1 reset", 16'(pd), 16'd0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(cnv_n && !busy, "R1 after reset", 16'(cnv_n), 16'd1);
    run_op(2'd0, 8'd0, 1'b0);   // R3 single
    run_op(2'd0, 8'd0, 1'b1);   // R3 + R10 poke while busy
    run_op(2'd1, 8'd3, 1'b1);   // R6 burst of three
    run_op(2'd1, 8'd0, 1'b0);   // R6 zero count runs one
    run_op(2'd2, 8'd0, 1'b0);   // R7 partial power-down
    run_op(2'd2, 8'd0, 1'b0);   // R10 ignored while down
    run_op(2'd3, 8'd0, 1'b0);   // R10 ignored while down
    run_op(2'd0, 8'd0, 1'b0);   // R9 wake then single
    run_op(2'd3, 8'd0, 1'b0);   // R8 full power-down
    run_op(2'd2, 8'd0, 1'b0);   // R10 ignored while down
    run_op(2'd1, 8'd2, 1'b0);   // R9 wake then burst
    run_op(2'd0, 8'd0, 1'b0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule